// File: doc/BRIEF.md
# Transmit Error Insertion Controller

This block arms single-shot error events for a DS3/E3 transmit formatter. Software writes a small control word with five insert bits and a two-bit framing-error code. Outside manual mode, an insert bit arms one error when it goes from 0 to 1. In manual mode, each change of level on an external trigger pin arms one error for every insert bit that is currently 1. Before an error is armed, it is checked against the line and framing configuration. Some error types are meaningless in some modes and are suppressed there.

Each armed error appears as a request line. The request behaves like a valid that stays high until the formatter accepts it. The formatter accepts it with a one-cycle consume strobe for that type, sent at the moment it applies the error. Back-pressure is implicit: the formatter consumes a request only at a frame position where that error can be placed. Until then the request simply stays high. A second arm of the same type while the request is pending merges into it and is not queued.

For framing errors the block presents the code that was latched when the error was armed. When a burst code is consumed, the block also outputs a count of the frames still to be corrupted. This count steps down on every frame tick.

Top module: `tx_err_arm_ctrl`

## Requirements
- R1: After reset, all requests are low, `frm_kind` and `burst_left` are 0, and the stored control word is 0, so the first write of a 1 to an insert bit is a 0-to-1 edge.
- R2: With `manual_mode`=0, a write in which insert bit i goes from 0 to 1 raises `req[i]` on the clock edge that takes the write. Writing a 1 to a bit that already holds 1 arms nothing. Bit indices: 0 bipolar violation, 1 excess zeros, 2 P-bit parity, 3 CP-bit parity, 4 framing. Write data bits 6:5 hold the framing code.
- R3: With `manual_mode`=1, register writes arm nothing. Each change of level on `man_trig`, rising or falling, arms `req[i]` for every insert bit i that is 1. The trigger passes through a two-flip-flop synchroniser, so the request rises on the third rising clock edge after the pin changes.
- R4: While `line_binary`=1, requests 0 and 1 are never raised, and a pending one is dropped on the next edge.
- R5: Request 2 is suppressed while `mode_e3`=1. Request 3 is suppressed while `mode_e3`=1 or `cbit_mode`=0. Request 4 is never suppressed.
- R6: A request stays high until a consume strobe for its type. After a consume without a new arm, it is low from the next edge. A repeated arm while the request is pending leaves it high and adds no second event.
- R7: `frm_kind` shows the two-bit framing code in force when the framing request was armed.
- R8: Consuming a framing request loads `burst_left` according to `frm_kind`. Code 10 loads 4. Code 11 loads 3 in DS3 mode and 4 in E3 mode. Codes 00 and 01 load 0. Each `frame_tick` then lowers a non-zero count by 1.
- R9: If an arm and a consume for the same type fall in the same cycle, the request stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Insert bits [4:0], framing code [6:5] |
| manual_mode | input | 1 | 1: arm from trigger pin toggles |
| man_trig | input | 1 | Asynchronous manual trigger pin |
| mode_e3 | input | 1 | 1: E3 framing, 0: DS3 framing |
| cbit_mode | input | 1 | 1: DS3 C-bit parity framing in use |
| line_binary | input | 1 | 1: line interface carries binary data |
| consume | input | 5 | Per-type accept strobes from formatter |
| frame_tick | input | 1 | One pulse per transmitted frame |
| req | output | 5 | Per-type pending error requests |
| frm_kind | output | 2 | Framing error code latched at arm |
| burst_left | output | 3 | Frames left in a framing error burst |

## Verification
Register mode is swept over every insert bit under all eight combinations of E3, C-bit and binary settings. This separates correct arming from mode suppression and exposes any crosstalk between types. Repeat writes of an unchanged word show whether the design is edge-sensitive or level-sensitive. Manual mode is swept over all 32 insert patterns. Each pattern is checked quiet for two edges after the pin toggles and then checked for the exact request mask, which pins down the synchroniser latency. The framing codes are swept against both framing modes to check the burst length, and the count-down is followed to zero. Directed cases cover reset, hold without a consume, drop on binary mode, and a consume that lands on the same cycle as a fresh arm.

// File: rtl/tx_err_pkg.sv
package tx_err_pkg;
  localparam int ERR_TYPES = 5;
  localparam int CODE_W    = 2;
  localparam int CFG_W     = ERR_TYPES + CODE_W;

  localparam int IDX_BPV   = 0;
  localparam int IDX_EXZ   = 1;
  localparam int IDX_PPAR  = 2;
  localparam int IDX_CPPAR = 3;
  localparam int IDX_FRAME = 4;

  typedef enum logic [CODE_W-1:0] {
    FK_ONE_F   = 2'b00,
    FK_ONE_M   = 2'b01,
    FK_BURST_F = 2'b10,
    FK_BURST_M = 2'b11
  } frm_kind_e;
endpackage

// File: rtl/tx_err_trig_sync.sv
module tx_err_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic toggle
);
  // sh[STAGES-1] is the synchronised level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], async_in};
  end

  assign toggle = sh[STAGES] ^ sh[STAGES-1];
endmodule

// File: rtl/tx_err_slot.sv
module tx_err_slot (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic consume,
  input  logic enable,
  output logic pending
);
  always_ff @(posedge clk) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= enable & (arm | (pending & ~consume));
  end

  AST_ARM_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    arm && enable |=> pending); // R9
  AST_HOLD_UNTIL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pending && !consume && enable |=> pending); // R6
  AST_TAKEN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    pending && consume && !arm |=> !pending); // R6
  AST_GATED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pending); // R4
endmodule

// File: rtl/tx_err_burst.sv
module tx_err_burst #(
  parameter int LONG  = 4,
  parameter int SHORT = 3,
  localparam int W    = $clog2(LONG + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [1:0]   kind,
  input  logic         e3,
  input  logic         tick,
  output logic [W-1:0] left
);
  logic [W-1:0] load_val;

  always_comb begin
    if (!kind[1])             load_val = '0;
    else if (kind[0] && !e3)  load_val = W'(SHORT);
    else                      load_val = W'(LONG);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                     left <= '0;
    else if (load)                  left <= load_val;
    else if (tick && left != '0)    left <= left - 1'b1;
  end

  AST_SINGLE_NO_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    load && !kind[1] |=> left == '0); // R8
  AST_BURST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load && tick && left != '0 |=> left == $past(left) - 1'b1); // R8
  AST_BURST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load && !tick |=> $stable(left)); // R8
endmodule

// File: rtl/tx_err_arm_ctrl.sv
module tx_err_arm_ctrl
  import tx_err_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BURST_LONG  = 4,
  parameter int BURST_SHORT = 3,
  localparam int LEFT_W     = $clog2(BURST_LONG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr,
  input  logic [CFG_W-1:0]     cfg_wdata,
  input  logic                 manual_mode,
  input  logic                 man_trig,
  input  logic                 mode_e3,
  input  logic                 cbit_mode,
  input  logic                 line_binary,
  input  logic [ERR_TYPES-1:0] consume,
  input  logic                 frame_tick,
  output logic [ERR_TYPES-1:0] req,
  output logic [CODE_W-1:0]    frm_kind,
  output logic [LEFT_W-1:0]    burst_left
);
  logic [CFG_W-1:0]     ctl_q;
  logic                 trig_tog;
  logic [ERR_TYPES-1:0] rise, arm, enable;
  frm_kind_e            kind_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (cfg_wr) ctl_q <= cfg_wdata;
  end

  tx_err_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(man_trig), .toggle(trig_tog)
  );

  always_comb begin
    enable            = '1;
    enable[IDX_BPV]   = ~line_binary;
    enable[IDX_EXZ]   = ~line_binary;
    enable[IDX_PPAR]  = ~mode_e3;
    enable[IDX_CPPAR] = ~mode_e3 & cbit_mode;
  end

  for (genvar i = 0; i < ERR_TYPES; i++) begin : g_slot
    assign rise[i] = cfg_wr & cfg_wdata[i] & ~ctl_q[i];
    assign arm[i]  = manual_mode ? (trig_tog & ctl_q[i]) : rise[i];

    tx_err_slot u_slot (
      .clk(clk), .rst_n(rst_n), .arm(arm[i]), .consume(consume[i]),
      .enable(enable[i]), .pending(req[i])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) kind_q <= FK_ONE_F;
    else if (arm[IDX_FRAME])
      kind_q <= frm_kind_e'(manual_mode ? ctl_q[CFG_W-1:ERR_TYPES]
                                        : cfg_wdata[CFG_W-1:ERR_TYPES]);
  end
  assign frm_kind = kind_q;

  tx_err_burst #(.LONG(BURST_LONG), .SHORT(BURST_SHORT)) u_burst (
    .clk(clk), .rst_n(rst_n), .load(consume[IDX_FRAME] & req[IDX_FRAME]),
    .kind(kind_q), .e3(mode_e3), .tick(frame_tick), .left(burst_left)
  );

  AST_BINARY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    line_binary |=> !req[IDX_BPV] && !req[IDX_EXZ]); // R4
  AST_E3_NO_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_e3 |=> !req[IDX_PPAR] && !req[IDX_CPPAR]); // R5
  AST_NO_CBIT_NO_CP: assert property (@(posedge clk) disable iff (!rst_n)
    !cbit_mode |=> !req[IDX_CPPAR]); // R5
  AST_MANUAL_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
    manual_mode && !trig_tog && req == '0 |=> req == '0); // R3
  AST_LEVEL_NO_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    !manual_mode && !cfg_wr && !req[IDX_FRAME] |=> !req[IDX_FRAME]); // R2
endmodule

// File: tb/tx_err_arm_ctrl_tb.sv
`timescale 1ns/1ps
module tx_err_arm_ctrl_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       cfg_wr = 0;
  logic [6:0] cfg_wdata = 0;
  logic       manual_mode = 0, man_trig = 0, mode_e3 = 0, cbit_mode = 1, line_binary = 0;
  logic [4:0] consume = 0;
  logic       frame_tick = 0;
  logic [4:0] req;
  logic [1:0] frm_kind;
  logic [2:0] burst_left;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_err_arm_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .manual_mode(manual_mode), .man_trig(man_trig), .mode_e3(mode_e3),
    .cbit_mode(cbit_mode), .line_binary(line_binary), .consume(consume),
    .frame_tick(frame_tick), .req(req), .frm_kind(frm_kind), .burst_left(burst_left)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string rq, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic wr(logic [6:0] v);
    cfg_wr = 1; cfg_wdata = v; step(); cfg_wr = 0;
  endtask

  task automatic take_all();
    consume = 5'h1f; step(); consume = 0;
  endtask

  function automatic logic [4:0] en_mask(bit e3, bit cb, bit bin);
    return {1'b1, !e3 && cb, !e3, !bin, !bin};
  endfunction

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    // R1 reset state
    chk("R1 req", req, 0);
    chk("R1 frm_kind", frm_kind, 0);
    chk("R1 burst_left", burst_left, 0);
    wr(7'h01);
    chk("R1 first write edge", req, 1);
    take_all(); wr(0);

    // R2 R4 R5: register mode sweep over modes and bits
    for (int m = 0; m < 8; m++) begin
      mode_e3 = m[0]; cbit_mode = m[1]; line_binary = m[2];
      for (int i = 0; i < 5; i++) begin
        logic [4:0] e;
        e = en_mask(m[0], m[1], m[2]);
        wr(0); take_all();
        wr(7'(1 << i));
        chk(i < 2 ? "R4 arm" : (i < 4 ? "R5 arm" : "R2 arm"), req, e[i] ? (1 << i) : 0);
        take_all();
        chk("R6 consume clears", req, 0);
        wr(7'(1 << i));
        chk("R2 level no rearm", req, 0);
      end
    end
    mode_e3 = 0; cbit_mode = 1; line_binary = 0;

    // R6 hold without consume
    wr(0); wr(7'h04);
    for (int k = 0; k < 5; k++) step();
    chk("R6 hold", req, 4);
    take_all();

    // R4 drop pending on binary
    wr(0); wr(7'h03);
    line_binary = 1; step();
    chk("R4 drop pending", req, 0);
    line_binary = 0; wr(0);

    // R3 manual sweep over all insert patterns
    manual_mode = 1;
    for (int p = 0; p < 32; p++) begin
      wr(0);
      wr(7'(p));
      chk("R3 write inert", req, 0);
      man_trig = ~man_trig;
      step(); step();
      chk("R3 sync latency", req, 0);
      step();
      chk("R3 toggle arms", req, p);
      take_all();
    end

    // R9 arm coincides with consume; R6 merge
    wr(7'h10);
    man_trig = ~man_trig; step(); step(); step();
    chk("R9 setup", req, 5'h10);
    man_trig = ~man_trig; step(); step();
    consume = 5'h10; step(); consume = 0;
    chk("R9 arm beats consume", req, 5'h10);
    man_trig = ~man_trig; step(); step(); step();
    chk("R6 merge pending", req, 5'h10);
    take_all();
    chk("R6 merged single event", req, 0);
    manual_mode = 0;

    // R7 R8 framing code sweep against both framing modes
    for (int e3 = 0; e3 < 2; e3++) begin
      for (int c = 0; c < 4; c++) begin
        int exp_left;
        mode_e3 = e3[0];
        exp_left = (c >= 2) ? ((c == 3 && e3 == 0) ? 3 : 4) : 0;
        wr(0); take_all();
        wr(7'((c << 5) | 16));
        chk("R7 kind latched", frm_kind, c);
        wr(7'(((3 - c) << 5) | 16));
        chk("R7 kind held", frm_kind, c);
        consume = 5'h10; step(); consume = 0;
        chk("R8 burst load", burst_left, exp_left);
        step();
        chk("R8 no tick hold", burst_left, exp_left);
        for (int t = exp_left; t > 0; t--) begin
          frame_tick = 1; step(); frame_tick = 0;
          chk("R8 burst step", burst_left, t - 1);
        end
        frame_tick = 1; step(); frame_tick = 0;
        chk("R8 burst floor", burst_left, 0);
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule